// File: doc/BRIEF.md
# Threaded-Code Dispatch Bus Interposer

This block sits between a memory read-data bus and the data input of an unmodified 8-bit CPU. It watches every opcode fetch. When the fetched opcode is the dispatch opcode 3Bh, it takes over the CPU's view of the bus for nine cycles. Over those cycles the CPU carries out a double-indirect jump through an interpretive pointer held outside the CPU.

The block first hands the CPU a jump-absolute opcode and the two pointer bytes. The CPU then fetches the code-field address from memory. The block captures that address, byte by byte, into a 16-bit holding register W. It puts a jump-indirect opcode in front of the captured bytes and replays each byte one cycle after it appeared on memory. The CPU therefore ends up jumping through the code field to the handler routine.

During the sequence the block asks the pointer logic for a double increment. After the sequence, W keeps the code-field address, so later code can index into the header.

Top module: `thread_dispatch_shim`

## Requirements
- R1: A cycle where the shim is idle, `op_sync` is 1 and `mem_rdata` is 3Bh is cycle 1 of a dispatch. In that same cycle `cpu_rdata` is 4Ch.
- R2: In cycle 2 of a dispatch `cpu_rdata` equals `ptr_addr[7:0]`. In cycle 3 it equals `ptr_addr[15:8]`. Memory data is ignored in both cycles.
- R3: In cycle 4 `cpu_rdata` is 6Ch, and the byte on `mem_rdata` is latched into `w_addr[7:0]`.
- R4: In cycle 5 `cpu_rdata` carries the memory byte of cycle 4, and the memory byte of cycle 5 is latched into `w_addr[15:8]`. In cycle 6 `cpu_rdata` carries the memory byte of cycle 5.
- R5: In cycles 7 to 9 `cpu_rdata` equals `mem_rdata`. Cycle 10 is an ordinary cycle, so a 3Bh opcode fetch there starts a new dispatch.
- R6: After a dispatch, `w_addr` holds {cycle-5 byte, cycle-4 byte} and keeps that value until the cycle 4 of the next dispatch.
- R7: `ptr_dinc_req` is a one-cycle pulse in cycle 4 of each dispatch, and it is low at all other times.
- R8: A 3Bh byte with `op_sync` at 0 starts nothing and is passed to the CPU unchanged.
- R9: `op_sync` and 3Bh in cycles 2 to 9 do not restart or lengthen the sequence.
- R10: While `rst_n` is 0 the shim returns to idle on the clock edge and clears W to 0. Idle means `cpu_rdata` follows memory, `ptr_dinc_req` is 0 and `w_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sync | input | 1 | High when the current CPU read is an opcode fetch |
| mem_rdata | input | 8 | Byte returned by memory this cycle |
| ptr_addr | input | 16 | Current interpretive pointer value |
| cpu_rdata | output | 8 | Byte presented to the CPU data input |
| w_addr | output | 16 | Captured code-field address (W) |
| ptr_dinc_req | output | 1 | Double-increment request to the pointer logic |

## Verification
The dispatch is driven with memory bytes that differ from the pointer bytes. This shows whether cycles 2 and 3 really come from the pointer and whether cycles 5 and 6 are the memory bytes of the cycle before, not of the current cycle. A 3Bh fetched as data is included, and so are sync pulses and 3Bh bytes placed inside the sequence. These separate true opcode detection from plain byte matching and from restarting part way through the sequence. Back-to-back dispatches, including one that starts in cycle 10, check the sequence length exactly. A reset in the middle of a dispatch, followed by a new pointer value, shows that W is cleared and that the pointer bytes are not stale.

// File: rtl/tds_pkg.sv
// Package: shared phase encoding and opcode constants for the dispatch shim.
// Assumes an 8-bit CPU data bus and a 16-bit pointer (two byte lanes).
package tds_pkg;

    localparam int BYTE_W  = 8;
    localparam int PTR_W   = 16;
    localparam int LANES   = PTR_W / BYTE_W;

    // Phase numbering matches dispatch cycle numbers; cycle 1 is idle+hit.
    typedef enum logic [3:0] {
        PH_IDLE   = 4'd0,
        PH_PTR_LO = 4'd2,
        PH_PTR_HI = 4'd3,
        PH_IND_OP = 4'd4,
        PH_CFA_LO = 4'd5,
        PH_CFA_HI = 4'd6,
        PH_PASS_A = 4'd7,
        PH_PASS_B = 4'd8,
        PH_PASS_C = 4'd9
    } phase_t;

    localparam logic [BYTE_W-1:0] OP_DISPATCH = 8'h3B;
    localparam logic [BYTE_W-1:0] OP_JMP_ABS  = 8'h4C;
    localparam logic [BYTE_W-1:0] OP_JMP_IND  = 8'h6C;

endpackage

// File: rtl/tds_detect.sv
// Module: tds_detect
// Flags cycle 1 of a dispatch: an opcode fetch of the dispatch opcode
// seen while the sequencer is idle. Purely combinational.
module tds_detect
    import tds_pkg::*;
#(
    parameter int                 DW       = BYTE_W,
    parameter logic [DW-1:0]      TRIG_OP  = OP_DISPATCH
) (
    input  logic          idle,
    input  logic          op_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic          hit
);

    // Match only on opcode fetches while no sequence is running.
    always_comb begin
        hit = idle && op_sync && (mem_rdata == TRIG_OP);
    end

endmodule

// File: rtl/tds_sequencer.sv
// Module: tds_sequencer
// Steps through dispatch cycles 2..9 after a hit, then returns to idle.
// Assumes hit is only raised while idle. Drives the double-increment pulse.
module tds_sequencer
    import tds_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hit,
    output phase_t phase,
    output logic   idle,
    output logic   dinc_req
);

    phase_t phase_q;

    // Phase register: idle -> 2 on hit, count up to 9, then back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE:   phase_q <= hit ? PH_PTR_LO : PH_IDLE;
                PH_PASS_C: phase_q <= PH_IDLE;
                default:   phase_q <= phase_t'(phase_q + 4'd1);
            endcase
        end
    end

    // Decoded status outputs of the phase register.
    always_comb begin
        phase    = phase_q;
        idle     = (phase_q == PH_IDLE);
        dinc_req = (phase_q == PH_IND_OP);
    end

endmodule

// File: rtl/tds_wreg.sv
// Module: tds_wreg
// Two-lane holding register W. Lane k captures memory data in phase
// PH_IND_OP + k, which makes it a one-cycle delay for the CPU stream.
module tds_wreg
    import tds_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NL = LANES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  phase_t         phase,
    input  logic [DW-1:0]  mem_rdata,
    output logic [NL*DW-1:0] w_value
);

    localparam logic [3:0] FIRST_CAP = 4'(PH_IND_OP);

    for (genvar lane = 0; lane < NL; lane++) begin : g_lane
        logic [DW-1:0] lane_q;

        // Capture this lane's byte in its own capture phase.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (4'(phase) == FIRST_CAP + 4'(lane)) begin
                lane_q <= mem_rdata;
            end
        end

        assign w_value[lane*DW +: DW] = lane_q;
    end

endmodule

// File: rtl/tds_busmux.sv
// Module: tds_busmux
// Selects the byte the CPU sees in each phase. Outside a dispatch it passes
// memory data through. Assumes PTR and W are both two bytes, low byte first.
module tds_busmux
    import tds_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = PTR_W
) (
    input  logic          hit,
    input  phase_t        phase,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] ptr_value,
    input  logic [AW-1:0] w_value,
    output logic [DW-1:0] cpu_rdata
);

    // Per-phase source selection for the CPU data input.
    always_comb begin
        case (phase)
            PH_IDLE:   cpu_rdata = hit ? OP_JMP_ABS : mem_rdata;
            PH_PTR_LO: cpu_rdata = ptr_value[DW-1:0];
            PH_PTR_HI: cpu_rdata = ptr_value[2*DW-1:DW];
            PH_IND_OP: cpu_rdata = OP_JMP_IND;
            PH_CFA_LO: cpu_rdata = w_value[DW-1:0];
            PH_CFA_HI: cpu_rdata = w_value[2*DW-1:DW];
            default:   cpu_rdata = mem_rdata;
        endcase
    end

endmodule

// File: rtl/thread_dispatch_shim.sv
// Module: thread_dispatch_shim (top)
// Rewrites the byte stream to the CPU so that one dispatch opcode becomes a
// jump through the pointer, then an indirect jump through the fetched
// code-field address. Assumes op_sync marks opcode fetches and that
// ptr_addr stays steady through cycles 2 and 3.
module thread_dispatch_shim
    import tds_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = PTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_sync,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] ptr_addr,
    output logic [DW-1:0] cpu_rdata,
    output logic [AW-1:0] w_addr,
    output logic          ptr_dinc_req
);

    localparam int NL = AW / DW;

    logic   hit;
    logic   idle;
    phase_t phase;

    tds_detect #(.DW(DW), .TRIG_OP(OP_DISPATCH)) u_detect (
        .idle      (idle),
        .op_sync   (op_sync),
        .mem_rdata (mem_rdata),
        .hit       (hit)
    );

    tds_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .phase    (phase),
        .idle     (idle),
        .dinc_req (ptr_dinc_req)
    );

    tds_wreg #(.DW(DW), .NL(NL)) u_wreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .mem_rdata (mem_rdata),
        .w_value   (w_addr)
    );

    tds_busmux #(.DW(DW), .AW(AW)) u_mux (
        .hit       (hit),
        .phase     (phase),
        .mem_rdata (mem_rdata),
        .ptr_value (ptr_addr),
        .w_value   (w_addr),
        .cpu_rdata (cpu_rdata)
    );

endmodule

// File: rtl/thread_dispatch_shim_chk.sv
// Module: thread_dispatch_shim_chk
// Checker for the dispatch shim, attached to the top module by bind below.
module thread_dispatch_shim_chk
    import tds_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        op_sync,
    input logic [7:0]  mem_rdata,
    input logic [15:0] ptr_addr,
    input logic [7:0]  cpu_rdata,
    input logic [15:0] w_addr,
    input logic        ptr_dinc_req,
    input logic [3:0]  phase
);

    // R1
    jmp_abs_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd0 && op_sync && mem_rdata == OP_DISPATCH) |-> cpu_rdata == OP_JMP_ABS);

    // R2
    ptr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd2) |-> cpu_rdata == ptr_addr[7:0]);

    // R2
    ptr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd3) |-> cpu_rdata == ptr_addr[15:8]);

    // R3
    jmp_ind_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd4) |-> cpu_rdata == OP_JMP_IND);

    // R4
    cfa_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd5 || phase == 4'd6) |-> cpu_rdata == $past(mem_rdata));

    // R5
    pass_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase >= 4'd7) |-> cpu_rdata == mem_rdata);

    // R6
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 4'd4 && phase != 4'd5) |=> $stable(w_addr));

    // R7
    dinc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_dinc_req |=> !ptr_dinc_req);

    // R7
    dinc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_dinc_req |-> cpu_rdata == OP_JMP_IND);

    // R8
    data_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd0 && !op_sync) |-> cpu_rdata == mem_rdata);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 4'd0 && phase != 4'd9) |=> phase == $past(phase) + 4'd1);

endmodule

bind thread_dispatch_shim thread_dispatch_shim_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_sync      (op_sync),
    .mem_rdata    (mem_rdata),
    .ptr_addr     (ptr_addr),
    .cpu_rdata    (cpu_rdata),
    .w_addr       (w_addr),
    .ptr_dinc_req (ptr_dinc_req),
    .phase        (phase)
);

// File: tb/tb_thread_dispatch_shim.sv
// Bench for thread_dispatch_shim: a vector table walked cycle by cycle,
// then directed tests for reset, pointer change and W retention.
module tb_thread_dispatch_shim;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_sync = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] ptr_addr = 16'h1234;
    logic [7:0]  cpu_rdata;
    logic [15:0] w_addr;
    logic        ptr_dinc_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    thread_dispatch_shim dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_sync      (op_sync),
        .mem_rdata    (mem_rdata),
        .ptr_addr     (ptr_addr),
        .cpu_rdata    (cpu_rdata),
        .w_addr       (w_addr),
        .ptr_dinc_req (ptr_dinc_req)
    );

    // Vector: {sync, mem byte, expected cpu byte, expected dinc}; ptr = 1234h
    localparam int NV = 23;
    localparam logic [17:0] VEC [NV] = '{
        {1'b1, 8'hA9, 8'hA9, 1'b0},  // R8 plain opcode passes
        {1'b0, 8'h3B, 8'h3B, 1'b0},  // R8 3Bh as data
        {1'b1, 8'h3B, 8'h4C, 1'b0},  // R1 cycle 1
        {1'b0, 8'h77, 8'h34, 1'b0},  // R2 cycle 2
        {1'b1, 8'h3B, 8'h12, 1'b0},  // R2 cycle 3, R9 sync ignored
        {1'b1, 8'hCD, 8'h6C, 1'b1},  // R3 R7 cycle 4
        {1'b0, 8'hAB, 8'hCD, 1'b0},  // R4 cycle 5
        {1'b0, 8'h3B, 8'hAB, 1'b0},  // R4 cycle 6
        {1'b1, 8'h3B, 8'h3B, 1'b0},  // R5 R9 cycle 7
        {1'b0, 8'h55, 8'h55, 1'b0},  // R5 cycle 8
        {1'b1, 8'h66, 8'h66, 1'b0},  // R5 cycle 9
        {1'b1, 8'hEA, 8'hEA, 1'b0},  // R5 cycle 10 normal fetch
        {1'b1, 8'h3B, 8'h4C, 1'b0},  // R1 second dispatch
        {1'b0, 8'h00, 8'h34, 1'b0},  // R2
        {1'b0, 8'h00, 8'h12, 1'b0},  // R2
        {1'b0, 8'h10, 8'h6C, 1'b1},  // R3 R7
        {1'b0, 8'h20, 8'h10, 1'b0},  // R4
        {1'b0, 8'h30, 8'h20, 1'b0},  // R4
        {1'b0, 8'h41, 8'h41, 1'b0},  // R5
        {1'b0, 8'h42, 8'h42, 1'b0},  // R5
        {1'b0, 8'h43, 8'h43, 1'b0},  // R5
        {1'b1, 8'h3B, 8'h4C, 1'b0},  // R5 restart in cycle 10
        {1'b0, 8'h99, 8'h34, 1'b0}   // R2
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, then let outputs settle.
    task automatic drive(input logic s, input logic [7:0] m);
        @(negedge clk);
        op_sync   = s;
        mem_rdata = m;
        #1;
    endtask

    initial begin
        #50000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) drive(1'b0, 8'h5A);
        chk("R10 cpu passthrough in reset", {8'h0, cpu_rdata}, 16'h005A);
        chk("R10 W cleared", w_addr, 16'h0000);
        chk("R10 dinc low", {15'h0, ptr_dinc_req}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][17], VEC[i][16:9]);
            chk($sformatf("R1-table row %0d cpu", i), {8'h0, cpu_rdata}, {8'h0, VEC[i][8:1]});
            chk($sformatf("R7 table row %0d dinc", i), {15'h0, ptr_dinc_req}, {15'h0, VEC[i][0]});
            if (i == 20) chk("R6 W after second dispatch", w_addr, 16'h2010);
        end
        chk("R6 W held into third dispatch", w_addr, 16'h2010);

        // R10 reset in the middle of the third dispatch (now in cycle 3)
        drive(1'b0, 8'h00);           // cycle 3
        drive(1'b0, 8'hEE);           // cycle 4, W low <= EE
        @(negedge clk);
        rst_n = 1'b0;
        op_sync = 1'b0;
        mem_rdata = 8'h3B;
        @(posedge clk);
        #1;
        chk("R10 W cleared mid-dispatch", w_addr, 16'h0000);
        chk("R10 cpu follows memory after reset", {8'h0, cpu_rdata}, 16'h003B);
        chk("R10 dinc low after reset", {15'h0, ptr_dinc_req}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 new pointer value
        ptr_addr = 16'hABCD;
        drive(1'b1, 8'h3B);
        chk("R1 dispatch after reset", {8'h0, cpu_rdata}, 16'h004C);
        drive(1'b0, 8'h01);
        chk("R2 new pointer low", {8'h0, cpu_rdata}, 16'h00CD);
        drive(1'b0, 8'h02);
        chk("R2 new pointer high", {8'h0, cpu_rdata}, 16'h00AB);
        drive(1'b0, 8'hF0);
        drive(1'b0, 8'h0F);
        drive(1'b0, 8'h00);
        chk("R4 high CFA byte replayed", {8'h0, cpu_rdata}, 16'h000F);
        repeat (3) drive(1'b0, 8'h11);

        // R6 W retained over idle cycles and 3Bh data bytes
        repeat (5) drive(1'b0, 8'h3B);
        chk("R6 W retained", w_addr, 16'h0FF0);
        chk("R8 3Bh data passes", {8'h0, cpu_rdata}, 16'h003B);
        chk("R7 no dinc while idle", {15'h0, ptr_dinc_req}, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule